// File: doc/BRIEF.md
# Checkpoint Undo Log Controller

This block holds a small direct-mapped store of data blocks and gives it a rollback capability. Every block carries a checkpoint-number tag next to its data, and a current checkpoint number (the epoch counter) advances by one on each checkpoint tick. When an update reaches a block for the first time in an epoch, the block's previous contents are pushed into a fixed-depth undo log before the new data lands. Later writes to the same block in the same epoch go straight through and add nothing to the log.

A recovery command carries a target epoch. The block then pops undo records newest-first and writes each saved image back into the store. It stops at the first record made before the target epoch. When it stops, it moves the epoch counter to the target and raises a one-cycle done pulse. A separate recovery-point input tells the block which epochs can no longer be rolled back. Records older than that point are released from the oldest end of the log, which frees space for new updates.

Callers must keep the recovery target no lower than the current recovery point and no higher than the current epoch. The recovery point must also stay at or below the current epoch.

Top module: `ckpt_undo_log`

## Requirements
- R1: After reset the epoch counter reads 0, every block holds data 0 and tag 0, the log is empty, `updReady` is 1 and `recBusy` is 0.
- R2: A `ckptTick` pulse outside recovery raises `ccnOut` by one on the next clock. A tick is ignored while `recBusy` or `recStart` is high.
- R3: An accepted update (`updValid` and `updReady` both high at a clock edge) writes the data, sets the block's tag to epoch+1, and one cycle later shows `rspValid`=1 with `rspTag` = epoch+1. The epoch used is the one current at acceptance.
- R4: An update logs the block's old data, old tag and the current epoch only when the epoch is greater than or equal to the block's tag. Repeated writes to one block within an epoch therefore use a single log entry.
- R5: When the log holds `LOG_DEPTH` entries, `updReady` is low. An update presented then changes neither the store nor `rspValid`.
- R6: `recStart` in normal operation latches `recTarget` and enters recovery (`recBusy`=1 from the next cycle). Each recovery cycle then pops the newest entry and restores that block's data and tag, as long as the entry's epoch is at or above the target.
- R7: When the newest entry is below the target, or the log is empty, recovery ends. In that cycle `recBusy` falls, `recDone` is high for exactly one cycle, and `ccnOut` equals the target.
- R8: `updReady` is low while `recStart` or `recBusy` is high, so no update is taken during recovery.
- R9: `rpAdvance` loads `rpNum` as the recovery point. Outside recovery, one entry per cycle whose epoch is below the recovery point is released from the oldest end of the log.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| ckptTick | input | 1 | Checkpoint tick: advance the epoch |
| updValid | input | 1 | Update request |
| updIdx | input | IW | Block index of the update |
| updData | input | DW | New block data |
| updReady | output | 1 | Update can be accepted this cycle |
| rspValid | output | 1 | Response for an update accepted last cycle |
| rspTag | output | CNW | Tag now held by the updated block |
| rdIdx | input | IW | Block index for the read port |
| rdData | output | DW | Data of block `rdIdx` |
| rdTag | output | CNW | Tag of block `rdIdx` |
| rpAdvance | input | 1 | Load a new recovery point |
| rpNum | input | CNW | New recovery point epoch |
| recStart | input | 1 | Begin rollback |
| recTarget | input | CNW | Epoch to roll back to |
| recBusy | output | 1 | Rollback in progress |
| recDone | output | 1 | One-cycle pulse when rollback ends |
| ccnOut | output | CNW | Current epoch |

## Verification
The logging rule is tested in three ways. The first is a run of writes to one block inside a single epoch; if every write were logged, the log would fill. The second spreads writes over several blocks and epochs until the log is full, which shows the stall. The third releases old records with the recovery point and checks that this frees space. Rollback is tested once as a directed case that empties a full log while an update and a tick are held high, and many more times from a random mix of writes, ticks, recovery-point moves and rollback targets. Each clock, a behavioural queue model is compared against the read port, the ready and response signals and the epoch counter. This shows whether restores happen in the wrong order or stop at the wrong epoch.

// File: rtl/ckpt_log_pkg.sv
package ckpt_log_pkg;

  typedef struct packed {
    logic writeUpd;
    logic push;
    logic popRestore;
    logic freeHead;
  } logStrobe_t;

  typedef enum logic {
    ST_RUN    = 1'b0,
    ST_UNROLL = 1'b1
  } ctrlState_t;

endpackage

// File: rtl/ckpt_log_dp.sv
module ckpt_log_dp
  import ckpt_log_pkg::*;
#(
  parameter int NBLK  = 8,
  parameter int DW    = 16,
  parameter int CNW   = 8,
  parameter int DEPTH = 8,
  parameter int IW    = $clog2(NBLK),
  parameter int PW    = $clog2(DEPTH)
) (
  input  logic           clk,
  input  logic           rstN,
  input  logStrobe_t     strb,
  input  logic [IW-1:0]  updIdx,
  input  logic [DW-1:0]  updData,
  input  logic [CNW-1:0] ccn,
  input  logic [IW-1:0]  rdIdx,
  output logic [DW-1:0]  rdData,
  output logic [CNW-1:0] rdTag,
  output logic [CNW-1:0] updBlkTag,
  output logic [CNW-1:0] topIntv,
  output logic [CNW-1:0] headIntv,
  output logic [PW:0]    logCount
);
  localparam int CW = PW + 1;

  logic [DW-1:0]  blkData [NBLK];
  logic [CNW-1:0] blkTag  [NBLK];

  logic [IW-1:0]  logIdx  [DEPTH];
  logic [DW-1:0]  logData [DEPTH];
  logic [CNW-1:0] logTag  [DEPTH];
  logic [CNW-1:0] logIntv [DEPTH];

  logic [PW-1:0] headPtr, tailPtr, topPtr;

  assign topPtr    = tailPtr - 1'b1;
  assign topIntv   = logIntv[topPtr];
  assign headIntv  = logIntv[headPtr];
  assign updBlkTag = blkTag[updIdx];
  assign rdData    = blkData[rdIdx];
  assign rdTag     = blkTag[rdIdx];

  // Block store: new writes and undo restores are mutually exclusive
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      for (int b = 0; b < NBLK; b++) begin
        blkData[b] <= '0;
        blkTag[b]  <= '0;
      end
    end else if (strb.writeUpd) begin
      blkData[updIdx] <= updData;
      blkTag[updIdx]  <= ccn + CNW'(1);
    end else if (strb.popRestore) begin
      blkData[logIdx[topPtr]] <= logData[topPtr];
      blkTag[logIdx[topPtr]]  <= logTag[topPtr];
    end
  end

  // Undo record array: written only in normal operation
  always_ff @(posedge clk) begin
    if (strb.push) begin
      logIdx[tailPtr]  <= updIdx;
      logData[tailPtr] <= blkData[updIdx];
      logTag[tailPtr]  <= blkTag[updIdx];
      logIntv[tailPtr] <= ccn;
    end
  end

  // Ring pointers: push/pop at the tail, release at the head
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      headPtr  <= '0;
      tailPtr  <= '0;
      logCount <= '0;
    end else begin
      tailPtr  <= tailPtr + PW'(strb.push) - PW'(strb.popRestore);
      headPtr  <= headPtr + PW'(strb.freeHead);
      logCount <= logCount + CW'(strb.push) - CW'(strb.popRestore)
                  - CW'(strb.freeHead);
    end
  end
endmodule

// File: rtl/ckpt_log_ctrl.sv
module ckpt_log_ctrl
  import ckpt_log_pkg::*;
#(
  parameter int CNW   = 8,
  parameter int DEPTH = 8,
  parameter int PW    = $clog2(DEPTH)
) (
  input  logic           clk,
  input  logic           rstN,
  input  logic           ckptTick,
  input  logic           updValid,
  output logic           updReady,
  output logic           rspValid,
  output logic [CNW-1:0] rspTag,
  input  logic           rpAdvance,
  input  logic [CNW-1:0] rpNum,
  input  logic           recStart,
  input  logic [CNW-1:0] recTarget,
  output logic           recBusy,
  output logic           recDone,
  output logic [CNW-1:0] ccn,
  input  logic [CNW-1:0] updBlkTag,
  input  logic [CNW-1:0] topIntv,
  input  logic [CNW-1:0] headIntv,
  input  logic [PW:0]    logCount,
  output logStrobe_t     strb
);
  localparam logic [PW:0] FULL_CNT = (PW+1)'(DEPTH);

  ctrlState_t     state;
  logic [CNW-1:0] rpReg, tgtReg;
  logic           accept, unrollHit, logEmpty;

  assign logEmpty  = (logCount == '0);
  assign recBusy   = (state == ST_UNROLL);
  assign updReady  = (state == ST_RUN) && !recStart && (logCount != FULL_CNT);
  assign accept    = updValid && updReady;
  assign unrollHit = recBusy && !logEmpty && (topIntv >= tgtReg);

  always_comb begin
    strb            = '0;
    strb.writeUpd   = accept;
    strb.push       = accept && (ccn >= updBlkTag);
    strb.popRestore = unrollHit;
    strb.freeHead   = (state == ST_RUN) && !recStart && !logEmpty
                      && (headIntv < rpReg);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state    <= ST_RUN;
      ccn      <= '0;
      rpReg    <= '0;
      tgtReg   <= '0;
      recDone  <= 1'b0;
      rspValid <= 1'b0;
      rspTag   <= '0;
    end else begin
      recDone  <= 1'b0;
      rspValid <= accept;
      if (accept) rspTag <= ccn + CNW'(1);
      if (rpAdvance) rpReg <= rpNum;
      unique case (state)
        ST_RUN: begin
          if (recStart) begin
            state  <= ST_UNROLL;
            tgtReg <= recTarget;
          end else if (ckptTick) begin
            ccn <= ccn + CNW'(1);
          end
        end
        ST_UNROLL: begin
          if (!unrollHit) begin
            state   <= ST_RUN;
            recDone <= 1'b1;
            ccn     <= tgtReg;
          end
        end
        default: state <= ST_RUN;
      endcase
    end
  end
endmodule

// File: rtl/ckpt_undo_log.sv
module ckpt_undo_log
  import ckpt_log_pkg::*;
#(
  parameter int NBLK      = 8,
  parameter int DW        = 16,
  parameter int CNW       = 8,
  parameter int LOG_DEPTH = 8,
  parameter int IW        = $clog2(NBLK)
) (
  input  logic           clk,
  input  logic           rstN,
  input  logic           ckptTick,
  input  logic           updValid,
  input  logic [IW-1:0]  updIdx,
  input  logic [DW-1:0]  updData,
  output logic           updReady,
  output logic           rspValid,
  output logic [CNW-1:0] rspTag,
  input  logic [IW-1:0]  rdIdx,
  output logic [DW-1:0]  rdData,
  output logic [CNW-1:0] rdTag,
  input  logic           rpAdvance,
  input  logic [CNW-1:0] rpNum,
  input  logic           recStart,
  input  logic [CNW-1:0] recTarget,
  output logic           recBusy,
  output logic           recDone,
  output logic [CNW-1:0] ccnOut
);
  localparam int PW = $clog2(LOG_DEPTH);

  logStrobe_t     strb;
  logic [CNW-1:0] updBlkTag, topIntv, headIntv;
  logic [PW:0]    logCount;

  ckpt_log_ctrl #(.CNW(CNW), .DEPTH(LOG_DEPTH), .PW(PW)) ctrl_i (
    .clk(clk), .rstN(rstN), .ckptTick(ckptTick), .updValid(updValid),
    .updReady(updReady), .rspValid(rspValid), .rspTag(rspTag),
    .rpAdvance(rpAdvance), .rpNum(rpNum), .recStart(recStart),
    .recTarget(recTarget), .recBusy(recBusy), .recDone(recDone),
    .ccn(ccnOut), .updBlkTag(updBlkTag), .topIntv(topIntv),
    .headIntv(headIntv), .logCount(logCount), .strb(strb)
  );

  ckpt_log_dp #(.NBLK(NBLK), .DW(DW), .CNW(CNW), .DEPTH(LOG_DEPTH),
                .IW(IW), .PW(PW)) dp_i (
    .clk(clk), .rstN(rstN), .strb(strb), .updIdx(updIdx),
    .updData(updData), .ccn(ccnOut), .rdIdx(rdIdx), .rdData(rdData),
    .rdTag(rdTag), .updBlkTag(updBlkTag), .topIntv(topIntv),
    .headIntv(headIntv), .logCount(logCount)
  );
endmodule

// File: rtl/ckpt_undo_log_chk.sv
module ckpt_undo_log_chk #(
  parameter int CNW = 8
) (
  input logic           clk,
  input logic           rstN,
  input logic           ckptTick,
  input logic           updValid,
  input logic           updReady,
  input logic           recStart,
  input logic           recBusy,
  input logic           recDone,
  input logic           rspValid,
  input logic [CNW-1:0] rspTag,
  input logic [CNW-1:0] ccnOut
);
  p_tick_step_r2: assert property (@(posedge clk) disable iff (!rstN)
    (ckptTick && !recBusy && !recStart) |=> ccnOut == CNW'($past(ccnOut) + 1'b1));

  p_rsp_tag_r3: assert property (@(posedge clk) disable iff (!rstN)
    (updValid && updReady) |=> (rspValid && rspTag == CNW'($past(ccnOut) + 1'b1)));

  p_enter_rec_r6: assert property (@(posedge clk) disable iff (!rstN)
    (recStart && !recBusy) |=> recBusy);

  p_done_on_exit_r7: assert property (@(posedge clk) disable iff (!rstN)
    $fell(recBusy) |-> recDone);

  p_done_single_r7: assert property (@(posedge clk) disable iff (!rstN)
    recDone |=> !recDone);

  p_done_not_busy_r7: assert property (@(posedge clk) disable iff (!rstN)
    recDone |-> !recBusy);

  p_refuse_rec_r8: assert property (@(posedge clk) disable iff (!rstN)
    (recBusy || recStart) |-> !updReady);
endmodule

bind ckpt_undo_log ckpt_undo_log_chk #(.CNW(CNW)) chk_i (
  .clk(clk), .rstN(rstN), .ckptTick(ckptTick), .updValid(updValid),
  .updReady(updReady), .recStart(recStart), .recBusy(recBusy),
  .recDone(recDone), .rspValid(rspValid), .rspTag(rspTag), .ccnOut(ccnOut)
);

// File: tb/ckpt_undo_log_tb_top.sv
module ckpt_undo_log_tb_top;
  localparam int NBLK = 8, DW = 16, CNW = 8, DEPTH = 8, IW = 3;

  logic clk = 1'b0, rstN = 1'b0;
  logic ckptTick = 0, updValid = 0, rpAdvance = 0, recStart = 0;
  logic [IW-1:0] updIdx = '0, rdIdx = '0;
  logic [DW-1:0] updData = '0;
  logic [CNW-1:0] rpNum = '0, recTarget = '0;
  logic updReady, rspValid, recBusy, recDone;
  logic [CNW-1:0] rspTag, rdTag, ccnOut;
  logic [DW-1:0] rdData;

  int checks = 0, failures = 0;

  always #2 clk = ~clk;

  ckpt_undo_log #(.NBLK(NBLK), .DW(DW), .CNW(CNW), .LOG_DEPTH(DEPTH)) dut_i (
    .clk(clk), .rstN(rstN), .ckptTick(ckptTick), .updValid(updValid),
    .updIdx(updIdx), .updData(updData), .updReady(updReady),
    .rspValid(rspValid), .rspTag(rspTag), .rdIdx(rdIdx), .rdData(rdData),
    .rdTag(rdTag), .rpAdvance(rpAdvance), .rpNum(rpNum), .recStart(recStart),
    .recTarget(recTarget), .recBusy(recBusy), .recDone(recDone), .ccnOut(ccnOut)
  );

  // ---------------- behavioural reference model ----------------
  typedef struct { int idx; int dat; int tag; int intv; } rec_t;
  rec_t q[$];
  int mData[NBLK], mTag[NBLK];
  int mCcn, mRp, mTgt, mRspTag;
  bit mBusy, mDone, mRspV;

  function automatic bit mReady();
    return (q.size() < DEPTH) && !mBusy && !recStart;
  endfunction

  always @(posedge clk) begin
    if (!rstN) begin
      q.delete();
      for (int b = 0; b < NBLK; b++) begin mData[b] = 0; mTag[b] = 0; end
      mCcn = 0; mRp = 0; mTgt = 0; mRspTag = 0;
      mBusy = 0; mDone = 0; mRspV = 0;
    end else begin
      bit rdy, newDone, newRspV, freeH;
      int newRp;
      rdy = mReady();
      newDone = 0; newRspV = 0;
      newRp = rpAdvance ? int'(rpNum) : mRp;
      if (mBusy) begin
        if (q.size() > 0 && q[$].intv >= mTgt) begin
          rec_t e;
          e = q.pop_back();
          mData[e.idx] = e.dat;
          mTag[e.idx] = e.tag;
        end else begin
          mBusy = 0; newDone = 1; mCcn = mTgt;
        end
      end else begin
        freeH = !recStart && q.size() > 0 && q[0].intv < mRp;
        if (recStart) begin
          mBusy = 1; mTgt = int'(recTarget);
        end else begin
          if (updValid && rdy) begin
            if (mCcn >= mTag[updIdx]) begin
              rec_t e;
              e.idx = int'(updIdx); e.dat = mData[updIdx];
              e.tag = mTag[updIdx]; e.intv = mCcn;
              q.push_back(e);
            end
            mTag[updIdx] = (mCcn + 1) % 256;
            mData[updIdx] = int'(updData);
            newRspV = 1;
            mRspTag = (mCcn + 1) % 256;
          end
          if (ckptTick) mCcn = (mCcn + 1) % 256;
        end
        if (freeH) void'(q.pop_front());
      end
      mRp = newRp; mDone = newDone; mRspV = newRspV;
    end
  end

  // ---------------- checking ----------------
  task automatic chk(string req, string what, longint act, longint exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s %s actual=%0d expected=%0d at %0t", req, what, act, exp, $time);
    end
  endtask

  task automatic compareAll();
    chk("R5/R8", "updReady", updReady, mReady());
    chk("R3", "rspValid", rspValid, mRspV);
    if (mRspV) chk("R3", "rspTag", rspTag, mRspTag);
    chk("R2/R7", "ccnOut", ccnOut, mCcn);
    chk("R6", "recBusy", recBusy, mBusy);
    chk("R7", "recDone", recDone, mDone);
    chk("R4/R6", "rdData", rdData, mData[rdIdx]);
    chk("R4/R6", "rdTag", rdTag, mTag[rdIdx]);
  endtask

  task automatic step();
    @(posedge clk);
    @(negedge clk);
    compareAll();
  endtask

  task automatic clearIn();
    ckptTick = 0; updValid = 0; rpAdvance = 0; recStart = 0;
  endtask

  task automatic upd(int idx, int dat);
    updIdx = IW'(idx); updData = DW'(dat); updValid = 1;
    step();
    updValid = 0;
  endtask

  task automatic tick();
    ckptTick = 1; step(); ckptTick = 0;
  endtask

  task automatic peek(int idx, string req, int expD, int expT);
    rdIdx = IW'(idx); #0.1;
    chk(req, "block data", rdData, expD);
    chk(req, "block tag", rdTag, expT);
  endtask

  task automatic summary();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    checks++; failures++;
    $display("FAIL watchdog actual=timeout expected=completion");
    summary();
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk); rstN = 1;
    step();
    // R1: reset state
    chk("R1", "ccnOut", ccnOut, 0);
    chk("R1", "updReady", updReady, 1);
    chk("R1", "recBusy", recBusy, 0);
    for (int b = 0; b < NBLK; b++) peek(b, "R1", 0, 0);

    // R3: first update in epoch 0
    upd(0, 'h11);
    chk("R3", "rspValid", rspValid, 1);
    chk("R3", "rspTag", rspTag, 1);
    peek(0, "R3", 'h11, 1);

    // R4: eight more writes to block 0 in the same epoch add no entries
    for (int k = 0; k < 8; k++) upd(0, 'h20 + k);
    chk("R4", "updReady after same-epoch writes", updReady, 1);

    // R2 / R5: new epoch, fill the log
    tick();
    chk("R2", "ccnOut after tick", ccnOut, 1);
    for (int b = 1; b < NBLK; b++) upd(b, 'h100 + b);
    chk("R5", "updReady when full", updReady, 0);
    upd(2, 'hBAD);
    chk("R5", "rspValid while full", rspValid, 0);
    peek(2, "R5", 'h102, 2);

    // R9: release epoch-0 entry
    rpNum = 1; rpAdvance = 1; step(); rpAdvance = 0;
    step();
    chk("R9", "updReady after release", updReady, 1);

    // R6/R7/R8: refill then roll back to epoch 1 with update and tick held
    tick();
    upd(3, 'h77);
    chk("R5", "updReady full again", updReady, 0);
    recTarget = 1; recStart = 1; step(); recStart = 0;
    chk("R6", "recBusy", recBusy, 1);
    updIdx = 5; updData = 'hEEEE; updValid = 1; ckptTick = 1;
    for (int n = 0; n < 20 && recBusy; n++) begin
      chk("R8", "updReady during recovery", updReady, 0);
      step();
    end
    chk("R7", "recDone", recDone, 1);
    chk("R7", "ccnOut at target", ccnOut, 1);
    clearIn();
    peek(0, "R6", 'h27, 1);
    for (int b = 1; b < NBLK; b++) peek(b, "R6", 0, 0);
    step();
    chk("R7", "recDone single", recDone, 0);

    // random mix
    for (int n = 0; n < 4000; n++) begin
      clearIn();
      rdIdx = IW'($urandom % NBLK);
      if (!mBusy) begin
        if ($urandom % 40 == 0) begin
          recStart = 1;
          recTarget = CNW'(mRp + int'($urandom % (mCcn - mRp + 1)));
        end else begin
          updValid = ($urandom % 2) == 1;
          updIdx = IW'($urandom % NBLK);
          updData = DW'($urandom);
          ckptTick = ($urandom % 12 == 0) && (mCcn < 240);
          if ($urandom % 25 == 0) begin
            rpAdvance = 1;
            rpNum = CNW'(mRp + int'($urandom % (mCcn - mRp + 1)));
          end
        end
      end else begin
        updValid = ($urandom % 2) == 1;
        ckptTick = ($urandom % 3) == 0;
      end
      step();
    end
    clearIn();
    step();
    summary();
    $finish;
  end
endmodule